// File: doc/BRIEF.md
# RMII Transmit Di-bit Serializer

This block sits on the MAC side of a reduced media-independent interface (RMII) link. It accepts a frame as a stream of bytes on a valid/ready handshake and turns it into the two-bit-per-clock transmit signals, the enable `tx_en` and the data pair `txd`. Everything runs on the free-running 50 MHz reference clock, and both outputs change only on its rising edges.

A frame begins when `in_valid` is sampled high while the block is idle and the inter-frame gap has elapsed. The block first sends the preamble: seven 0x55 bytes and then the 0xD5 start-of-frame delimiter. It then serializes each payload byte as four di-bits, starting with the least significant pair. A byte marked with `in_last` closes the frame. Between frames the block holds `tx_en` low and drives `txd` to 00. It does not generate the frame check sequence, handle collisions or support 10 Mbps operation.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While `rst_n` is sampled low, and on the clock after the reset edge, `tx_en` is 0, `txd` is 00 and `in_ready` is 0.
- R2: When `in_valid` is sampled high at a clock edge while the block is idle and the gap of R9 has elapsed, `tx_en` goes high on the next clock and that first di-bit is 01.
- R3: The preamble is 32 di-bits: 31 of value 01, followed by 11. This is seven 0x55 bytes and one 0xD5 byte, each sent low pair first. `in_ready` stays low for the first 31 of these di-bits.
- R4: Each payload byte goes out on four consecutive clocks, in the order bits [1:0], [3:2], [5:4], [7:6].
- R5: `in_ready` is high only on the clock carrying the fourth di-bit of the delimiter or of a payload byte that was not marked last. A byte is transferred at a clock edge where `in_valid` and `in_ready` are both high. Payload di-bits follow the delimiter with no gap.
- R6: `tx_en` stays high on every di-bit of the frame. It is low on the clock after the fourth di-bit of the byte that was transferred with `in_last` high.
- R7: `txd` is 00 on every clock on which `tx_en` is low.
- R8: If `in_valid` is low on a clock where `in_ready` is high, no byte is taken. The frame then ends after the di-bit already on the wire, so `tx_en` is low on the next clock.
- R9: Between two frames, `tx_en` stays low for at least 48 clocks. If the next frame is already requested, the low time is exactly 49 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz free-running reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source has a byte (or requests a frame while idle) |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final byte of the frame |
| in_ready | output | 1 | Byte on `in_data` is taken at this edge if `in_valid` |
| tx_en | output | 1 | Transmit enable |
| txd | output | 2 | Transmit di-bit, 00 while idle |

## Verification
The test frames are built to expose different faults. A single-byte frame checks the preamble-to-payload boundary and the smallest envelope. A four-byte frame with the values 0x00, 0xFF, 0x1B and 0xE4 puts a different value on each di-bit position, so a reversed pair order or a swapped bit within a pair produces a visible mismatch. That frame is requested while the previous one is still on the wire, which fixes the gap length exactly and shows that `in_data` has no effect before `in_ready`. A frame whose source runs dry without a last marker checks that the frame ends early (R8). The frame after it confirms that the block starts cleanly again.

// File: rtl/rmii_tx_pkg.sv
// Shared definitions for the RMII transmit serializer.
// Assumes an 8-bit byte and a two-bit transmit data path.
package rmii_tx_pkg;
    localparam int BYTE_W  = 8;
    localparam int DIBIT_W = 2;
    localparam logic [BYTE_W-1:0] PREAMBLE_BYTE = 8'h55;
    localparam logic [BYTE_W-1:0] DELIM_BYTE    = 8'hD5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;
endpackage

// File: rtl/rmii_tx_dibit.sv
// Di-bit shifter: holds the byte on the wire and shifts it right by one
// di-bit per clock while running. After four shifts with no reload it holds
// zero, so the output pair idles at 00 without any gating.
// Assumes load and run come from the sequencer on the same clock.
module rmii_tx_dibit
    import rmii_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [BYTE_W-1:0]   load_val,
    input  logic                run,
    output logic [DIBIT_W-1:0]  dibit,
    output logic                byte_end
);
    localparam int SLOTS = BYTE_W / DIBIT_W;
    localparam int CW    = $clog2(SLOTS);

    logic [BYTE_W-1:0] sh_q;
    logic [CW-1:0]     slot_q;

    assign dibit    = sh_q[DIBIT_W-1:0];
    assign byte_end = (slot_q == CW'(SLOTS - 1));

    // Shift register: load a new byte or drain one di-bit per running clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_val;
        end else if (run) begin
            sh_q <= {{DIBIT_W{1'b0}}, sh_q[BYTE_W-1:DIBIT_W]};
        end
    end

    // Slot counter: position of the current di-bit within its byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (load) begin
            slot_q <= '0;
        end else if (run) begin
            slot_q <= byte_end ? '0 : slot_q + 1'b1;
        end
    end

    // R4: the slot advances by exactly one on each running clock inside a byte.
    a_r4_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !byte_end) |=> (slot_q == $past(slot_q) + 1'b1));

    // R7: a byte that ends with no reload leaves the wire at 00.
    a_r7_drain_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (run && byte_end && !load) |=> (dibit == '0));
endmodule

// File: rtl/rmii_tx_gap.sv
// Inter-frame gap counter: counts the clocks with the transmitter inactive
// and saturates at MIN_IDLE. A new frame may start only at saturation.
// After reset the gap counts as already elapsed.
module rmii_tx_gap #(
    parameter int MIN_IDLE = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic gap_ok
);
    localparam int GW = $clog2(MIN_IDLE + 1);

    logic [GW-1:0] idle_q;

    assign gap_ok = (idle_q == GW'(MIN_IDLE));

    // Idle counter: cleared while transmitting, counts up to MIN_IDLE otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= GW'(MIN_IDLE);
        end else if (active) begin
            idle_q <= '0;
        end else if (!gap_ok) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // R9: the transmitter only turns on after the full gap has elapsed.
    a_r9_gap_met: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(gap_ok));
endmodule

// File: rtl/rmii_tx_ctrl.sv
// Frame sequencer: runs idle -> preamble -> payload -> idle. It chooses which
// byte the shifter loads and offers in_ready on the final di-bit of the
// delimiter or of each payload byte that is not marked last.
// Assumes byte_end comes from the shifter's slot counter.
module rmii_tx_ctrl
    import rmii_tx_pkg::*;
#(
    parameter int PRE_BYTES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              byte_end,
    input  logic              gap_ok,
    output logic              in_ready,
    output logic              active,
    output logic              load,
    output logic [BYTE_W-1:0] load_val
);
    localparam int PW = $clog2(PRE_BYTES + 1);

    tx_state_e     st_q;
    logic [PW-1:0] pre_idx_q;
    logic          last_q;
    logic          start, at_delim, offer, take, pre_next;

    // Handshake and load decisions for this clock.
    always_comb begin
        start    = (st_q == ST_IDLE) && in_valid && gap_ok;
        at_delim = (st_q == ST_PRE) && (pre_idx_q == PW'(PRE_BYTES));
        offer    = byte_end && (at_delim || ((st_q == ST_DATA) && !last_q));
        take     = offer && in_valid;
        pre_next = (st_q == ST_PRE) && byte_end && !at_delim;
        load     = start || take || pre_next;
        if (take) begin
            load_val = in_data;
        end else if (pre_next && (pre_idx_q == PW'(PRE_BYTES - 1))) begin
            load_val = DELIM_BYTE;
        end else begin
            load_val = PREAMBLE_BYTE;
        end
    end

    assign in_ready = offer;
    assign active   = (st_q != ST_IDLE);

    // State register: advances on the last di-bit of every byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            pre_idx_q <= '0;
            last_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q      <= ST_PRE;
                        pre_idx_q <= '0;
                        last_q    <= 1'b0;
                    end
                end
                ST_PRE: begin
                    if (byte_end) begin
                        if (at_delim) begin
                            st_q   <= take ? ST_DATA : ST_IDLE;
                            last_q <= in_last;
                        end else begin
                            pre_idx_q <= pre_idx_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_end) begin
                        if (take) begin
                            last_q <= in_last;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R5: ready is only offered on a byte's final di-bit while transmitting.
    a_r5_ready_slot: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (byte_end && active));

    // R6: the final di-bit of the last-marked byte ends the frame.
    a_r6_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DATA) && last_q && byte_end) |=> !active);

    // R8: an offer with no data ends the frame on the next clock.
    a_r8_underrun_end: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> !active);
endmodule

// File: rtl/rmii_tx_serializer.sv
// RMII transmit serializer top: a byte stream with valid/ready/last in,
// tx_en and the two-bit txd out, all on the 50 MHz reference clock.
// Assumes the source keeps in_valid high from frame request to last byte.
module rmii_tx_serializer #(
    parameter int PRE_BYTES = 7,
    parameter int MIN_IDLE  = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    output logic       tx_en,
    output logic [1:0] txd
);
    logic       active, gap_ok, byte_end, load;
    logic [7:0] load_val;

    rmii_tx_ctrl #(.PRE_BYTES(PRE_BYTES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .byte_end (byte_end),
        .gap_ok   (gap_ok),
        .in_ready (in_ready),
        .active   (active),
        .load     (load),
        .load_val (load_val)
    );

    rmii_tx_dibit u_dibit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .run      (active),
        .dibit    (txd),
        .byte_end (byte_end)
    );

    rmii_tx_gap #(.MIN_IDLE(MIN_IDLE)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .gap_ok (gap_ok)
    );

    assign tx_en = active;

    // R7: the data pair is idle whenever the enable is low.
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 2'b00));

    // R2: the enable rises together with the first preamble di-bit.
    a_r2_first_dibit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 2'b01));

    // R1: the clock after a reset edge leaves everything idle.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!tx_en && !in_ready && (txd == 2'b00)));
endmodule

// File: tb/tb_rmii_tx_serializer.sv
// Scoreboard bench: the driver pushes the expected di-bits of each frame and
// the monitor compares them against the wire at every falling edge.
module tb_rmii_tx_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready, tx_en;
    logic [1:0] txd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [1:0] q_d[$];
    bit         q_r[$];
    string      q_tag[$];
    int         q_len[$];
    bit         q_exact[$];
    logic [7:0] frame_bytes[$];

    bit prev_en = 1'b0;
    int low_run = 0;
    int frames_seen = 0;
    int cur_len = 0;
    int seen = 0;

    always #10 clk = ~clk;

    rmii_tx_serializer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .tx_en(tx_en), .txd(txd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: queue the expected wire image, then hand the bytes over.
    task automatic send_frame(input bit mark_last, input bit check_start, input bit exact);
        int n;
        n = frame_bytes.size();
        q_len.push_back(32 + 4 * n);
        q_exact.push_back(exact);
        for (int i = 0; i < 32; i++) begin
            q_d.push_back(i == 31 ? 2'b11 : 2'b01);
            q_r.push_back(i == 31);
            q_tag.push_back(i == 0 ? "R2" : "R3");
        end
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 4; k++) begin
                q_d.push_back(frame_bytes[i][2*k +: 2]);
                q_r.push_back((k == 3) && !(mark_last && i == n - 1));
                q_tag.push_back("R4");
            end
        end
        if (check_start) @(negedge clk);
        in_valid = 1'b1;
        in_data  = frame_bytes[0];
        in_last  = mark_last && (n == 1);
        if (check_start) begin
            @(negedge clk);
            check(tx_en == 1'b1, "R2", int'(tx_en), 1);
            check(txd == 2'b01, "R2", int'(txd), 1);
        end
        for (int i = 0; i < n; i++) begin
            in_data = frame_bytes[i];
            in_last = mark_last && (i == n - 1);
            do @(negedge clk); while (!in_ready);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        frame_bytes.delete();
    endtask

    // Monitor: compare every di-bit and ready flag, and measure gaps.
    always @(negedge clk) begin
        if (!rst_n) begin
            check(tx_en == 1'b0, "R1", int'(tx_en), 0);
            check(txd == 2'b00, "R1", int'(txd), 0);
            check(in_ready == 1'b0, "R1", int'(in_ready), 0);
        end else if (tx_en) begin
            if (!prev_en) begin
                if (frames_seen > 0) begin
                    check(low_run >= 48, "R9", low_run, 48);
                    if (q_exact.size() > 0 && q_exact[0])
                        check(low_run == 49, "R9", low_run, 49);
                end
                if (q_exact.size() > 0) void'(q_exact.pop_front());
                frames_seen++;
                cur_len = (q_len.size() > 0) ? q_len.pop_front() : 0;
                seen = 0;
            end
            seen++;
            if (q_d.size() == 0) begin
                check(1'b0, "R6", int'(txd), -1);
            end else begin
                logic [1:0] ed;
                bit er;
                string et;
                ed = q_d.pop_front();
                er = q_r.pop_front();
                et = q_tag.pop_front();
                check(txd == ed, et, int'(txd), int'(ed));
                check(in_ready == er, "R5", int'(in_ready), int'(er));
            end
            low_run = 0;
        end else begin
            check(txd == 2'b00, "R7", int'(txd), 0);
            check(in_ready == 1'b0, "R5", int'(in_ready), 0);
            if (prev_en) check(seen == cur_len, "R6/R8", seen, cur_len);
            low_run++;
        end
        prev_en = rst_n && tx_en;
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        // R2 R3 R4: single-byte frame right after reset.
        frame_bytes = '{8'hA7};
        send_frame(1'b1, 1'b1, 1'b0);
        // R4 R9: distinct pair values, requested while the previous frame runs.
        frame_bytes = '{8'h00, 8'hFF, 8'h1B, 8'hE4};
        send_frame(1'b1, 1'b0, 1'b1);
        repeat (120) @(posedge clk);
        #1;
        // R8: the source stops without a last marker.
        frame_bytes = '{8'h3C, 8'h96};
        send_frame(1'b0, 1'b1, 1'b0);
        repeat (120) @(posedge clk);
        #1;
        // R5 R6: normal frame after the early end.
        frame_bytes = '{8'h5A, 8'h81, 8'hC3};
        send_frame(1'b1, 1'b1, 1'b0);
        repeat (80) @(posedge clk);
        @(negedge clk);
        check(q_d.size() == 0, "R6", q_d.size(), 0);
        check(tx_en == 1'b0, "R6", int'(tx_en), 0);
        summary();
    end
endmodule